// File: doc/BRIEF.md
# Segmented Indexed Vector Dot-Product Unit

This block multiplies and accumulates over a scalable vector of 16-bit elements into 64-bit lanes. Each 64-bit accumulator lane gains the sum of four products. The left factors of those products come from the four 16-bit elements of the first source that sit inside the lane itself. The right factors come from the second source, but not element by element. Within each 128-bit segment, a one-bit index picks one of the two 64-bit halves of that segment. The four elements of the chosen half are then broadcast to both result lanes of the same segment. Each segment takes its right factors from its own data only, never from a neighbour, at every vector length.

A single-bit mode input selects the arithmetic. In signed mode the elements are sign-extended before the multiply. In unsigned mode they are zero-extended. Sums wrap modulo 2^64. The request side uses a valid/ready handshake. It carries the accumulator, both sources, the index and the mode. The result vector comes back from a register one cycle after the handshake and is held until the consumer takes it.

Top module: `seg_idx_dot`

## Requirements
- R1: Result lane i (bits 64i+63..64i) equals accumulator lane i plus the sum over k=0..3 of the products of a first-source element and a second-source element.
- R2: For lane i, the first-source elements are the 16-bit elements numbered 4i+k, where element n occupies bits 16n+15..16n.
- R3: For lane i, the second-source elements are those numbered 8·floor(i/2) + 4·idx + k. Both lanes of a 128-bit segment therefore use the same four elements, taken from that segment.
- R4: With `req_signed`=1 the elements are sign-extended to 64 bits before multiplying. With `req_signed`=0 they are zero-extended.
- R5: Accumulation wraps modulo 2^64, with no saturation.
- R6: Each accepted request (`req_valid` and `req_ready` high at a clock edge) makes `res_valid` high with its result after that edge. Without an accepted request, a consumed result leaves `res_valid` low.
- R7: While `res_valid` is high and `res_ready` is low, `req_ready` is low, and `res_valid` and `res_data` stay unchanged.
- R8: After reset, `res_valid` is 0 and `req_ready` is 1.
- R9: `VEC_BITS` must be a multiple of 128 in the range 128 to 2048. Any other value stops elaboration.
- R10: With all first-source elements set to 1, second-source element n set to floor(n/4), and a zero accumulator, lanes 2j and 2j+1 give 8j for idx 0 and 8j+4 for idx 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_acc | input | VEC_BITS | Accumulator lanes, 64 bits each |
| req_a | input | VEC_BITS | First source, 16-bit elements |
| req_b | input | VEC_BITS | Second source, 16-bit elements |
| req_idx | input | 1 | Half of each 128-bit segment supplying the second-source elements |
| req_signed | input | 1 | 1 for signed, 0 for unsigned |
| res_valid | output | 1 | Result held |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | VEC_BITS | Result lanes, 64 bits each |

## Verification
The bench builds the unit twice, at 2048 bits (32 lanes, 16 segments) and at 128 bits (one segment), and drives both from the same stimulus. The wide build exposes segment selection for segments 2 and up. A fault there repeats a neighbour's lane pair, which the ramp pattern and the random operands both reveal. The narrow build checks the degenerate single-segment case and the lowest legal parameter value.

// File: rtl/seg_idx_dot.sv
module seg_idx_dot #(
  parameter int VEC_BITS = 512
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [VEC_BITS-1:0] req_acc,
  input  logic [VEC_BITS-1:0] req_a,
  input  logic [VEC_BITS-1:0] req_b,
  input  logic                req_idx,
  input  logic                req_signed,
  output logic                res_valid,
  input  logic                res_ready,
  output logic [VEC_BITS-1:0] res_data
);
  localparam int EW    = 16;
  localparam int LW    = 64;
  localparam int LANES = VEC_BITS / LW;
  localparam int PER   = LW / EW;
  localparam int SEGL  = 128 / LW;

  // R9: legal vector lengths only
  if ((VEC_BITS % 128) != 0 || VEC_BITS < 128 || VEC_BITS > 2048) begin : g_bad_len
    $error("seg_idx_dot: VEC_BITS must be a multiple of 128 within 128..2048");
  end

  function automatic logic [LW-1:0] widen(input logic [EW-1:0] e, input logic s);
    return {{(LW-EW){s & e[EW-1]}}, e};
  endfunction

  logic [VEC_BITS-1:0] lane_sum;
  logic                take;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LW-1:0] acc_q;
    always_comb begin
      acc_q = req_acc[i*LW +: LW];
      for (int k = 0; k < PER; k++) begin
        acc_q = acc_q + widen(req_a[(PER*i + k)*EW +: EW], req_signed)
                      * widen(req_b[((i/SEGL)*SEGL*PER + PER*int'(req_idx) + k)*EW +: EW], req_signed);
      end
    end
    assign lane_sum[i*LW +: LW] = acc_q;
  end

  assign req_ready = !res_valid || res_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else if (take) begin
      res_valid <= 1'b1;
      res_data  <= lane_sum;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/seg_idx_dot_chk.sv
module seg_idx_dot_chk #(
  parameter int VEC_BITS = 512
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic [VEC_BITS-1:0] req_acc,
  input logic [VEC_BITS-1:0] req_a,
  input logic                res_valid,
  input logic                res_ready,
  input logic [VEC_BITS-1:0] res_data
);
  p_result_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> res_valid);

  p_no_phantom_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!(req_valid && req_ready) && (!res_valid || res_ready)) |=> !res_valid);

  p_ready_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !req_ready);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  p_pair_shares_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_a[63:0] == req_a[127:64] && req_acc[63:0] == req_acc[127:64])
    |=> res_data[63:0] == res_data[127:64]);
endmodule

bind seg_idx_dot seg_idx_dot_chk #(.VEC_BITS(VEC_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_acc(req_acc), .req_a(req_a), .res_valid(res_valid),
  .res_ready(res_ready), .res_data(res_data)
);

// File: tb/test_seg_idx_dot.sv
module test_seg_idx_dot;
  localparam int WB = 2048;
  localparam int WS = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_idx = 1'b0, req_signed = 1'b0, res_ready = 1'b1;
  logic [WB-1:0] acc = '0, a = '0, b = '0;
  logic rdy_b, rdy_s, val_b, val_s;
  logic [WB-1:0] res_b;
  logic [WS-1:0] res_s;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  seg_idx_dot #(.VEC_BITS(WB)) i_seg_idx_dot (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_b),
    .req_acc(acc), .req_a(a), .req_b(b), .req_idx(req_idx), .req_signed(req_signed),
    .res_valid(val_b), .res_ready(res_ready), .res_data(res_b));

  seg_idx_dot #(.VEC_BITS(WS)) i_seg_idx_dot_min (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_s),
    .req_acc(acc[WS-1:0]), .req_a(a[WS-1:0]), .req_b(b[WS-1:0]), .req_idx(req_idx),
    .req_signed(req_signed), .res_valid(val_s), .res_ready(res_ready), .res_data(res_s));

  localparam int unsigned SEEDS [8] = '{32'h1234_5678, 32'hDEAD_BEEF, 32'h0BAD_F00D, 32'h7777_1111,
                                       32'hA5A5_5A5A, 32'h0000_0001, 32'hFEDC_BA98, 32'h3141_5926};
  localparam bit [1:0] MODES [8] = '{2'b00, 2'b01, 2'b10, 2'b11, 2'b01, 2'b10, 2'b11, 2'b00};

  function automatic logic [WB-1:0] fill(input int unsigned seed);
    logic [WB-1:0] v;
    int unsigned x = seed;
    for (int w = 0; w < WB/32; w++) begin
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      v[w*32 +: 32] = x;
    end
    return v;
  endfunction

  function automatic logic [WB-1:0] model(input logic [WB-1:0] ac, input logic [WB-1:0] av,
                                          input logic [WB-1:0] bv, input logic ix, input logic sg);
    logic [WB-1:0] r;
    for (int i = 0; i < WB/64; i++) begin
      longint t = longint'(ac[i*64 +: 64]);
      for (int k = 0; k < 4; k++) begin
        logic [15:0] ea = av[(4*i + k)*16 +: 16];
        logic [15:0] eb = bv[((i - i%2)*4 + ix*4 + k)*16 +: 16];
        longint xa = sg ? longint'($signed(ea)) : longint'({48'b0, ea});
        longint xb = sg ? longint'($signed(eb)) : longint'({48'b0, eb});
        t = t + xa * xb;
      end
      r[i*64 +: 64] = t;
    end
    return r;
  endfunction

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic check_res(input string req, input logic [WB-1:0] exp);
    checks++;
    if (!val_b || !val_s || res_b !== exp || res_s !== exp[WS-1:0]) begin
      errors++;
      for (int i = 0; i < WB/64; i++)
        if (res_b[i*64 +: 64] !== exp[i*64 +: 64]) begin
          $display("FAIL %s: lane %0d actual=%h expected=%h", req, i, res_b[i*64 +: 64], exp[i*64 +: 64]);
          break;
        end
      if (res_s !== exp[WS-1:0]) $display("FAIL %s: narrow actual=%h expected=%h", req, res_s, exp[WS-1:0]);
      if (!val_b || !val_s) $display("FAIL %s: valid actual=%0b%0b expected=11", req, val_b, val_s);
    end
  endtask

  task automatic run_one(input string req, input logic [WB-1:0] ac, input logic [WB-1:0] av,
                         input logic [WB-1:0] bv, input logic ix, input logic sg, input logic [WB-1:0] exp);
    @(negedge clk);
    acc = ac; a = av; b = bv; req_idx = ix; req_signed = sg; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check_res(req, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R6: watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [WB-1:0] ramp, ones, e1, e2, x1, x2;
    repeat (3) @(negedge clk);
    check_bit("R8 res_valid", val_b | val_s, 1'b0);
    check_bit("R8 req_ready", rdy_b & rdy_s, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R8 res_valid after release", val_b | val_s, 1'b0);

    // R1 R2 R3 R4: table walk of random operands, both index values and both modes
    for (int t = 0; t < 8; t++) begin
      logic [WB-1:0] ac = fill(SEEDS[t]);
      logic [WB-1:0] av = fill(SEEDS[t] ^ 32'h5555_0000);
      logic [WB-1:0] bv = fill(SEEDS[t] + 32'h0101_0101);
      run_one("R1 R2 R3 R4 random", ac, av, bv, MODES[t][1], MODES[t][0],
              model(ac, av, bv, MODES[t][1], MODES[t][0]));
    end

    // R10 R3: ramp pattern, lane pair j gives 8j (idx 0) or 8j+4 (idx 1)
    ones = '0;
    for (int n = 0; n < WB/16; n++) begin
      ones[n*16 +: 16] = 16'd1;
      ramp[n*16 +: 16] = 16'(n / 4);
    end
    for (int ix = 0; ix < 2; ix++) begin
      logic [WB-1:0] exp;
      for (int i = 0; i < WB/64; i++) exp[i*64 +: 64] = 64'(8*(i/2) + 4*ix);
      run_one(ix == 0 ? "R10 ramp idx0" : "R10 ramp idx1", '0, ones, ramp, 1'(ix), 1'b1, exp);
    end

    // R4: all-ones elements times one, signed gives -4, unsigned gives 4*65535
    begin
      logic [WB-1:0] ff = '1, es, eu;
      for (int i = 0; i < WB/64; i++) begin
        es[i*64 +: 64] = 64'hFFFF_FFFF_FFFF_FFFC;
        eu[i*64 +: 64] = 64'd262140;
      end
      run_one("R4 signed", '0, ff, ones, 1'b0, 1'b1, es);
      run_one("R4 unsigned", '0, ff, ones, 1'b1, 1'b0, eu);
      // R5: all-ones accumulator plus four wraps to 3
      for (int i = 0; i < WB/64; i++) eu[i*64 +: 64] = 64'd3;
      run_one("R5 wrap", ff, ones, ones, 1'b0, 1'b0, eu);
    end

    // R7 R6: hold under back-pressure, then accept the queued request
    x1 = fill(32'h0F0F_0F0F); x2 = fill(32'h1357_9BDF);
    e1 = model(x1, x2, x1, 1'b1, 1'b1);
    e2 = model(x2, x1, x2, 1'b0, 1'b0);
    @(negedge clk);
    res_ready = 1'b0;
    acc = x1; a = x2; b = x1; req_idx = 1'b1; req_signed = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    acc = x2; a = x1; b = x2; req_idx = 1'b0; req_signed = 1'b0;
    check_bit("R7 ready low while held", rdy_b | rdy_s, 1'b0);
    check_res("R7 first result", e1);
    @(negedge clk);
    check_res("R7 result stable", e1);
    res_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check_res("R6 queued request", e2);
    @(negedge clk);
    check_bit("R6 single result", val_b | val_s, 1'b0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule